// File: doc/BRIEF.md
# Guest Sleep Handshake Controller

This block sits on the host side of a legacy guest processor that can put itself to sleep. When the guest reports sleep entry with a one-cycle pulse, three things happen. The block latches a sleep status flag. It captures the current guest keypad-control value into a host wake-match register. If the host has enabled it, the block also raises a level interrupt.

Host software services the event through a 16-bit control register. To resume the guest, the host writes the acknowledge bit and the wake bit in the same access. Only that combined write produces the one-cycle wake pulse to the guest. A write that acknowledges without waking clears the flag and the interrupt, and the guest stays asleep. This closes the window in which a separate acknowledge could let the guest come out of sleep early.

Top module: `guest_sleep_ctl`

## Requirements
- R1: After reset, the control read value, the interrupt, the wake pulse, the keypad-control register and the wake-match register are all 0.
- R2: A `guest_sleep` pulse makes control bit 1 read 1 from the following cycle on, whatever the value of bit 15.
- R3: A control write with bit 0 and bit 1 both 1, made while bit 1 reads 1, drives `guest_wake` high for exactly the one cycle after the write edge. The same write clears bit 1.
- R4: `host_irq` is high exactly when bit 1 reads 1 and bit 15 (the interrupt enable) is 1. With bit 15 at 0, no interrupt is raised even though bit 1 is set.
- R5: On a `guest_sleep` pulse, `wake_match` takes the value `pad_q` held at that edge. Writes to the keypad-control register do not change `wake_match` at any other time.
- R6: A control write with bit 1 set and bit 0 clear clears bit 1 and the interrupt, and produces no wake pulse.
- R7: A control write with bit 0 set and bit 1 clear produces no wake pulse and leaves bit 1 set.
- R8: Bit 15 reads back the last value written to it. Bit 0 and bits 2 to 14 always read 0.
- R9: When a `guest_sleep` pulse and an acknowledge write fall in the same cycle, bit 1 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read value |
| pad_wr | input | 1 | Keypad-control register write strobe |
| pad_wdata | input | 16 | Keypad-control write data |
| pad_q | output | 16 | Keypad-control register value |
| wake_match | output | 16 | Copy of keypad-control taken at sleep entry |
| guest_sleep | input | 1 | Guest sleep-entry pulse |
| guest_wake | output | 1 | One-cycle wake command to the guest |
| host_irq | output | 1 | Host interrupt, level |

## Verification
The bench targets the split acknowledge. A write of only bit 1, or only bit 0, must never wake the guest. A design that woke on either bit alone would resume the guest early or with its flag still set. The bench also checks that a combined write with no sleep pending stays silent, and that the wake is exactly one cycle wide; a level wake would hold the guest in a repeated resume. Finally, it covers a sleep entry colliding with an acknowledge, the interrupt with the enable off, and keypad writes made after capture, which would expose a wake-match register that tracks instead of latching.

// File: rtl/guest_sleep_ctl.sv
module guest_sleep_ctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         pad_wr,
  input  logic [W-1:0] pad_wdata,
  output logic [W-1:0] pad_q,
  output logic [W-1:0] wake_match,
  input  logic         guest_sleep,
  output logic         guest_wake,
  output logic         host_irq
);
  localparam int EN_BIT = W - 1;

  logic asleep, irq_en;
  logic ack_wr, wake_req;

  assign ack_wr   = reg_wr && reg_wdata[1];
  assign wake_req = ack_wr && reg_wdata[0] && asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      irq_en     <= 1'b0;
      guest_wake <= 1'b0;
      pad_q      <= '0;
      wake_match <= '0;
    end else begin
      guest_wake <= wake_req;
      if (reg_wr) irq_en <= reg_wdata[EN_BIT];
      if (guest_sleep) asleep <= 1'b1;
      else if (ack_wr) asleep <= 1'b0;
      if (pad_wr) pad_q <= pad_wdata;
      if (guest_sleep) wake_match <= pad_q;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[1]      = asleep;
    reg_rdata[EN_BIT] = irq_en;
  end

  assign host_irq = asleep && irq_en;

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    guest_sleep |=> reg_rdata[1]);

  p_wake_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guest_wake |-> $past(reg_wr && reg_wdata[0] && reg_wdata[1]));

  p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guest_wake |=> !guest_wake);

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> (reg_rdata[EN_BIT] && reg_rdata[1]));

  p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    guest_sleep |=> wake_match == $past(pad_q));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !guest_sleep |=> $stable(wake_match));

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[1] && !guest_sleep) |=> (!reg_rdata[1] && !host_irq));

  p_zero_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[EN_BIT-1:2] == '0 && !reg_rdata[0]);
endmodule

// File: tb/guest_sleep_ctl_test.sv
module guest_sleep_ctl_test;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, pad_wr = 0, guest_sleep = 0;
  logic [15:0] reg_wdata = '0, pad_wdata = '0;
  logic [15:0] reg_rdata, pad_q, wake_match;
  logic        guest_wake, host_irq;
  int total = 0, bad = 0;
  bit done = 0;

  guest_sleep_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_wr(pad_wr), .pad_wdata(pad_wdata),
    .pad_q(pad_q), .wake_match(wake_match), .guest_sleep(guest_sleep),
    .guest_wake(guest_wake), .host_irq(host_irq));

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(logic [15:0] d, output logic woke);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(posedge clk); #1; woke = guest_wake; reg_wr = 0;
  endtask

  task automatic write_pad(logic [15:0] d);
    @(negedge clk); pad_wr = 1; pad_wdata = d;
    @(posedge clk); #1; pad_wr = 0;
  endtask

  task automatic sleep_pulse();
    @(negedge clk); guest_sleep = 1;
    @(posedge clk); #1; guest_sleep = 0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 16'h0);
    check("R1 irq", {15'b0, host_irq}, 16'h0);
    check("R1 wake", {15'b0, guest_wake}, 16'h0);
    check("R1 pad", pad_q, 16'h0);
    check("R1 match", wake_match, 16'h0);
  endtask

  task automatic t_sleep_no_irq();
    logic w;
    write_ctl(16'h0000, w);
    write_pad(16'h03A5);
    sleep_pulse();
    check("R2 flag", reg_rdata, 16'h0002);
    check("R4 irq off", {15'b0, host_irq}, 16'h0);
    check("R5 copy", wake_match, 16'h03A5);
    write_pad(16'h1234);
    check("R5 hold", wake_match, 16'h03A5);
    check("R5 pad", pad_q, 16'h1234);
  endtask

  task automatic t_partial_writes();
    logic w;
    write_ctl(16'h8001, w);
    check("R7 no wake", {15'b0, w}, 16'h0);
    check("R7 flag kept", reg_rdata, 16'h8002);
    check("R4 irq on", {15'b0, host_irq}, 16'h1);
    write_ctl(16'h8002, w);
    check("R6 no wake", {15'b0, w}, 16'h0);
    @(negedge clk);
    check("R6 no wake late", {15'b0, guest_wake}, 16'h0);
    check("R6 flag clear", reg_rdata, 16'h8000);
    check("R6 irq clear", {15'b0, host_irq}, 16'h0);
  endtask

  task automatic t_combined_wake();
    logic w;
    write_ctl(16'h8003, w);
    check("R3 idle no wake", {15'b0, w}, 16'h0);
    sleep_pulse();
    check("R2 flag en", reg_rdata, 16'h8002);
    check("R4 irq", {15'b0, host_irq}, 16'h1);
    check("R5 copy2", wake_match, 16'h1234);
    write_ctl(16'h8003, w);
    check("R3 wake", {15'b0, w}, 16'h1);
    check("R3 flag clear", reg_rdata, 16'h8000);
    @(posedge clk); #1;
    check("R3 one cycle", {15'b0, guest_wake}, 16'h0);
  endtask

  task automatic t_readback();
    logic w;
    write_ctl(16'h7FFC, w);
    check("R8 reserved zero", reg_rdata, 16'h0000);
    write_ctl(16'hFFFC, w);
    check("R8 enable back", reg_rdata, 16'h8000);
  endtask

  task automatic t_collide();
    @(negedge clk); guest_sleep = 1; reg_wr = 1; reg_wdata = 16'h8002;
    @(posedge clk); #1; guest_sleep = 0; reg_wr = 0;
    check("R9 flag wins", reg_rdata, 16'h8002);
    check("R9 no wake", {15'b0, guest_wake}, 16'h0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_sleep_no_irq();
    t_partial_writes();
    t_combined_wake();
    t_readback();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule